// File: doc/BRIEF.md
# Atomic Compare-and-Swap Sequencer

This block carries out a single-operand compare-and-swap. A start request brings in a 16-bit opcode, one extension word, an effective address that was computed elsewhere, and the current condition-code bits. The block first checks that the addressing mode points at memory. It then reads the operand at the operand size given by the opcode and compares it with a compare register. When the two are equal it writes an update register back to the same address. When they differ it loads the memory value into the compare register.

The eight data registers sit inside the block. Outside logic can write them and read them back through a simple side port. A lock output covers the whole read-modify-write window, so that a bus arbiter can keep other masters away from that location. Completion is a one-cycle done pulse. A disallowed addressing mode ends the operation without any bus activity and raises an illegal-instruction request with its vector number.

Top module: `cas_seq`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and mem_lock_o are low, ccr_o is zero, and every data register reads zero.
- R2: Opcode bits 11..9 select the operand size: 3'b101 selects byte, 3'b110 selects word, and any other value selects long. mem_size_o reports the size as 0 for byte, 1 for word and 2 for long, and the bus carries the operand in its low bits.
- R3: The addressing mode is in opcode bits 5..3 and the register field in bits 2..0. Modes 0 and 1, and mode 7 with a register field of 4 or more, end the operation with illegal_o and done_o high together and exc_vec_o = 4. In that case there is no memory access, no register changes and ccr_o equals the ccr_i sampled at start.
- R4: ccr_o is {X,N,Z,V,C}, bit 4 down to bit 0. After a legal operation, X equals the X bit of ccr_i. N, Z, V and C are the flags of (compare register minus memory operand) at the operand size, with N and V taken at bit 7, 15 or 31. This holds whether or not the values match.
- R5: When the size-masked compare register equals the size-masked operand, exactly one write goes to the same address, carrying the size-masked update register. The compare register is left unchanged.
- R6: On a mismatch no memory write occurs. The compare register takes the operand in its low byte or low word and keeps its upper bits. At long size it takes the whole operand.
- R7: mem_lock_o stays high from the read request through the write handshake, or through the cycle that decides not to write. A request holds its address and direction until mem_ready_i is seen.
- R8: done_o is a one-cycle pulse. On a legal completion, cost_o reads 20 during that pulse.
- R9: A start_i that arrives while busy_o is high is ignored and does not cause a second completion.
- R10: Extension word bits 8..6 index the update register and bits 2..0 index the compare register. All other extension bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| opcode_i | input | 16 | Instruction opcode |
| ext_i | input | 16 | Extension word holding the register indices |
| addr_i | input | AW | Precomputed operand address |
| ccr_i | input | 5 | Condition bits {X,N,Z,V,C} at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Illegal-instruction request (with done_o) |
| exc_vec_o | output | 8 | Exception vector number, 4 when illegal_o is high |
| cost_o | output | 8 | Reported cycle cost during a legal done_o |
| ccr_o | output | 5 | Resulting condition bits {X,N,Z,V,C} |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_lock_o | output | 1 | Read-modify-write lock |
| mem_size_o | output | 2 | Access size: 0 byte, 1 word, 2 long |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | 32 | Write data, right-aligned |
| mem_rdata_i | input | 32 | Read data, right-aligned |
| mem_ready_i | input | 1 | Memory accepts or completes the request |
| reg_we_i | input | 1 | External register write strobe |
| reg_widx_i | input | 3 | External register write index |
| reg_wdata_i | input | 32 | External register write data |
| reg_ridx_i | input | 3 | External register read index |
| reg_rdata_o | output | 32 | External register read data |

## Verification
The main sweep covers all eight size codes. It uses operands whose low bits match while their upper bits differ. A design that compared or wrote the full word would then fail to swap at byte or word size, or would clobber the upper memory bits. Sign-boundary values such as 0x7F against 0x80 and 0x8000 against 0x7FFF catch an overflow or borrow flag taken at the wrong bit. The mismatch cases catch a merge that zeroes or overwrites the upper register bits. All 64 mode and register combinations are swept, which catches a legality decoder that lets a register-direct or immediate form reach the bus. A second start during a slow read would, in a design that restarted, produce two done pulses or touch the wrong register.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } opsize_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_READ  = 3'd2,
    ST_EVAL  = 3'd3,
    ST_WRITE = 3'd4,
    ST_FIN   = 3'd5,
    ST_TRAP  = 3'd6
  } seq_state_e;

  localparam int unsigned OPW       = 32;
  localparam logic [7:0]  TRAP_VEC  = 8'd4;
  localparam logic [7:0]  SWAP_COST = 8'd20;

  function automatic logic [OPW-1:0] size_mask(opsize_e s);
    case (s)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_WORD: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] size_msb(opsize_e s);
    case (s)
      SZ_BYTE: size_msb = 5'd7;
      SZ_WORD: size_msb = 5'd15;
      default: size_msb = 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cas_decode.sv
module cas_decode
  import cas_pkg::*;
(
  input  logic [15:0] opcode_i,
  output opsize_e     size_o,
  output logic        legal_o
);

  logic [2:0] sz_field;
  logic [2:0] ea_mode;
  logic [2:0] ea_reg;

  assign sz_field = opcode_i[11:9];
  assign ea_mode  = opcode_i[5:3];
  assign ea_reg   = opcode_i[2:0];

  always_comb begin
    case (sz_field)
      3'b101:  size_o = SZ_BYTE;
      3'b110:  size_o = SZ_WORD;
      default: size_o = SZ_LONG;
    endcase
  end

  always_comb begin
    case (ea_mode)
      3'd0, 3'd1: legal_o = 1'b0;
      3'd7:       legal_o = (ea_reg < 3'd4);
      default:    legal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cas_flags.sv
module cas_flags
  import cas_pkg::*;
(
  input  logic [OPW-1:0] lhs_i,
  input  logic [OPW-1:0] rhs_i,
  input  opsize_e        size_i,
  output logic           n_o,
  output logic           z_o,
  output logic           v_o,
  output logic           c_o,
  output logic           eq_o
);

  logic [OPW-1:0] msk;
  logic [OPW-1:0] a_m;
  logic [OPW-1:0] b_m;
  logic [OPW-1:0] diff;
  logic [4:0]     top;

  always_comb begin
    msk  = size_mask(size_i);
    top  = size_msb(size_i);
    a_m  = lhs_i & msk;
    b_m  = rhs_i & msk;
    diff = (a_m - b_m) & msk;
    n_o  = diff[top];
    z_o  = (diff == '0);
    c_o  = (b_m > a_m);
    v_o  = (a_m[top] != b_m[top]) && (diff[top] != a_m[top]);
    eq_o = (a_m == b_m);
  end

endmodule

// File: rtl/cas_regfile.sv
module cas_regfile #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 8,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ra_idx_i,
  input  logic [IW-1:0] rb_idx_i,
  input  logic [IW-1:0] rc_idx_i,
  output logic [DW-1:0] ra_o,
  output logic [DW-1:0] rb_o,
  output logic [DW-1:0] rc_o
);

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = we_i && (widx_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (hit) begin
        regs_q[g] <= wdata_i;
      end
    end
  end

  assign ra_o = regs_q[ra_idx_i];
  assign rb_o = regs_q[rb_idx_i];
  assign rc_o = regs_q[rc_idx_i];

endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 8,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [15:0]   opcode_i,
  input  logic [15:0]   ext_i,
  input  logic [AW-1:0] addr_i,
  input  logic [4:0]    ccr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic [7:0]    exc_vec_o,
  output logic [7:0]    cost_o,
  output logic [4:0]    ccr_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_lock_o,
  output logic [1:0]    mem_size_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ready_i,
  input  logic          reg_we_i,
  input  logic [IW-1:0] reg_widx_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic [IW-1:0] reg_ridx_i,
  output logic [31:0]   reg_rdata_o
);

  seq_state_e     st_q, st_d;
  logic [15:0]    opc_q;
  logic [15:0]    ext_q;
  logic [AW-1:0]  addr_q;
  logic [OPW-1:0] opnd_q, opnd_d;
  logic [4:0]     ccr_q, ccr_d;
  logic           accept;
  logic           ccr_en;
  logic           opnd_en;

  opsize_e        size;
  logic           ea_ok;
  logic [OPW-1:0] msk;
  logic [IW-1:0]  dc_idx;
  logic [IW-1:0]  du_idx;
  logic [OPW-1:0] dc_val;
  logic [OPW-1:0] du_val;
  logic [OPW-1:0] merged;
  logic           f_n, f_z, f_v, f_c, f_eq;

  logic           int_we;
  logic           rf_we;
  logic [IW-1:0]  rf_widx;
  logic [OPW-1:0] rf_wdata;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign dc_idx = ext_q[0 +: IW];
  assign du_idx = ext_q[6 +: IW];
  assign msk    = size_mask(size);
  assign merged = (dc_val & ~msk) | (opnd_q & msk);

  cas_decode u_decode (
    .opcode_i (opc_q),
    .size_o   (size),
    .legal_o  (ea_ok)
  );

  cas_flags u_flags (
    .lhs_i  (dc_val),
    .rhs_i  (opnd_q),
    .size_i (size),
    .n_o    (f_n),
    .z_o    (f_z),
    .v_o    (f_v),
    .c_o    (f_c),
    .eq_o   (f_eq)
  );

  // internal merge wins over the side port
  assign rf_we    = int_we | reg_we_i;
  assign rf_widx  = int_we ? dc_idx : reg_widx_i;
  assign rf_wdata = int_we ? merged : reg_wdata_i;

  cas_regfile #(
    .DW   (OPW),
    .NREG (NREG)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (rf_we),
    .widx_i   (rf_widx),
    .wdata_i  (rf_wdata),
    .ra_idx_i (dc_idx),
    .rb_idx_i (du_idx),
    .rc_idx_i (reg_ridx_i),
    .ra_o     (dc_val),
    .rb_o     (du_val),
    .rc_o     (reg_rdata_o)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    opnd_d    = opnd_q;
    ccr_d     = ccr_q;
    ccr_en    = 1'b0;
    opnd_en   = 1'b0;
    int_we    = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_CHECK;
          ccr_d  = ccr_i;
          ccr_en = 1'b1;
        end
      end
      ST_CHECK: st_d = ea_ok ? ST_READ : ST_TRAP;
      ST_READ: begin
        mem_req_o = 1'b1;
        if (mem_ready_i) begin
          opnd_d  = mem_rdata_i & msk;
          opnd_en = 1'b1;
          st_d    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        ccr_d  = {ccr_q[4], f_n, f_z, f_v, f_c};
        ccr_en = 1'b1;
        if (f_eq) begin
          st_d = ST_WRITE;
        end else begin
          int_we = 1'b1;
          st_d   = ST_FIN;
        end
      end
      ST_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ready_i) st_d = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      ST_TRAP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= '0;
      ext_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      opc_q  <= opcode_i;
      ext_q  <= ext_i;
      addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
    end else if (opnd_en) begin
      opnd_q <= opnd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= '0;
    end else if (ccr_en) begin
      ccr_q <= ccr_d;
    end
  end

  // outputs
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN) || (st_q == ST_TRAP);
  assign illegal_o   = (st_q == ST_TRAP);
  assign exc_vec_o   = illegal_o ? TRAP_VEC : 8'd0;
  assign cost_o      = (st_q == ST_FIN) ? SWAP_COST : 8'd0;
  assign ccr_o       = ccr_q;
  assign mem_lock_o  = (st_q == ST_READ) || (st_q == ST_EVAL) || (st_q == ST_WRITE);
  assign mem_size_o  = size;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = du_val & msk;

  // R7
  lock_covers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_lock_o);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  lock_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_lock_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R4
  eval_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVAL) |-> (f_z == f_eq));

  // R5
  write_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> ccr_o[2]);

  // R3
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($past(!mem_req_o) && (exc_vec_o == 8'd4)));

endmodule

// File: tb/test_cas_seq.sv
module test_cas_seq;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] opcode_i;
  logic [15:0] ext_i;
  logic [31:0] addr_i;
  logic [4:0]  ccr_i;
  logic        busy_o, done_o, illegal_o;
  logic [7:0]  exc_vec_o, cost_o;
  logic [4:0]  ccr_o;
  logic        mem_req_o, mem_we_o, mem_lock_o;
  logic [1:0]  mem_size_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_ready_i;
  logic        reg_we_i;
  logic [2:0]  reg_widx_i;
  logic [31:0] reg_wdata_i;
  logic [2:0]  reg_ridx_i;
  logic [31:0] reg_rdata_o;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;

  cas_seq i_cas_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .ext_i(ext_i), .addr_i(addr_i), .ccr_i(ccr_i), .busy_o(busy_o),
    .done_o(done_o), .illegal_o(illegal_o), .exc_vec_o(exc_vec_o),
    .cost_o(cost_o), .ccr_o(ccr_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_lock_o(mem_lock_o), .mem_size_o(mem_size_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .reg_we_i(reg_we_i), .reg_widx_i(reg_widx_i), .reg_wdata_i(reg_wdata_i),
    .reg_ridx_i(reg_ridx_i), .reg_rdata_o(reg_rdata_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // memory responder
  logic [31:0] mmem [16];
  int unsigned lat = 0;
  logic [3:0]  wcnt;
  int unsigned n_rd, n_wr, n_done;
  logic [1:0]  last_sz;

  function automatic logic [31:0] msk_of(int unsigned w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic int unsigned bits_of_code(logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 32;
  endfunction

  assign mem_ready_i = mem_req_o && (wcnt == 4'd0);
  assign mem_rdata_i = mmem[mem_addr_o[3:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt    <= 4'd0;
      n_rd    <= 0;
      n_wr    <= 0;
      n_done  <= 0;
      last_sz <= 2'd3;
    end else begin
      if (done_o) n_done <= n_done + 1;
      if (mem_req_o) begin
        if (wcnt == 4'd0) begin
          wcnt    <= lat[3:0];
          last_sz <= mem_size_o;
          if (mem_we_o) begin
            mmem[mem_addr_o[3:0]] = (mmem[mem_addr_o[3:0]] & ~msk_of(bits_of_code(mem_size_o)))
                                  | (mem_wdata_o & msk_of(bits_of_code(mem_size_o)));
            n_wr <= n_wr + 1;
          end else begin
            n_rd <= n_rd + 1;
          end
        end else begin
          wcnt <= wcnt - 4'd1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic setreg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_we_i    = 1'b1;
    reg_widx_i  = idx;
    reg_wdata_i = val;
    @(negedge clk);
    reg_we_i    = 1'b0;
  endtask

  task automatic getreg(input logic [2:0] idx, output logic [31:0] val);
    reg_ridx_i = idx;
    #1;
    val = reg_rdata_o;
  endtask

  logic        r_ill;
  logic [7:0]  r_vec, r_cost;
  bit          r_to;

  task automatic run_op(input logic [15:0] opc, input logic [15:0] ext,
                        input logic [31:0] addr, input logic [4:0] ccr_in);
    int k;
    @(negedge clk);
    start_i  = 1'b1;
    opcode_i = opc;
    ext_i    = ext;
    addr_i   = addr;
    ccr_i    = ccr_in;
    @(negedge clk);
    start_i  = 1'b0;
    k = 0;
    while (!done_o && k < 100) begin
      @(negedge clk);
      k++;
    end
    r_to   = !done_o;
    r_ill  = illegal_o;
    r_vec  = exc_vec_o;
    r_cost = cost_o;
    if (r_to) chk(1'b0, "R8 timeout", 32'd0, 32'd1);
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_nzvc(logic [31:0] a0, logic [31:0] b0, int unsigned w);
    logic [31:0] m;
    longint a, b, sa, sb, half, diff, d;
    logic n, z, v, c;
    m    = msk_of(w);
    a    = longint'(a0 & m);
    b    = longint'(b0 & m);
    half = longint'(1) << (w - 1);
    d    = (a - b) & longint'(m);
    n    = ((d >> (w - 1)) & 1) != 0;
    z    = (d == 0);
    c    = (b > a);
    sa   = (a >= half) ? a - 2 * half : a;
    sb   = (b >= half) ? b - 2 * half : b;
    diff = sa - sb;
    v    = (diff > half - 1) || (diff < -half);
    return {n, z, v, c};
  endfunction

  function automatic logic [31:0] edge_val(int k);
    case (k % 12)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0080;
      2:  return 32'h0000_007F;
      3:  return 32'h0000_00FF;
      4:  return 32'h0000_8000;
      5:  return 32'h0000_7FFF;
      6:  return 32'h8000_0000;
      7:  return 32'h7FFF_FFFF;
      8:  return 32'hFFFF_FFFF;
      9:  return 32'h1234_5678;
      10: return 32'hC0DE_0101;
      default: return 32'h0001_0000;
    endcase
  endfunction

  logic [31:0] rng = 32'hACE1_2468;
  function automatic logic [31:0] next_rng(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // one legal compare-and-swap with full checking
  task automatic do_case(input logic [2:0] sc, input logic [2:0] dci, input logic [2:0] dui,
                         input logic [31:0] dcv, input logic [31:0] duv, input logic [31:0] memv,
                         input logic [2:0] mode, input logic [3:0] adr, input logic [4:0] ccr_in);
    int unsigned w;
    logic [31:0] m, got, rd0, wr0;
    logic [15:0] opc, ext;
    bit match;
    w = (sc == 3'b101) ? 8 : (sc == 3'b110) ? 16 : 32;
    m = msk_of(w);
    setreg(dci, dcv);
    setreg(dui, duv);
    mmem[adr] = memv;
    lat = (lat + 1) % 3;
    rd0 = n_rd;
    wr0 = n_wr;
    opc = {4'b0000, sc, 3'b011, mode, 3'b001};
    ext = 16'hA038 | {7'd0, dui, 3'd0, dci};
    run_op(opc, ext, {28'd0, adr}, ccr_in);
    match = ((dcv & m) == (memv & m));
    chk(r_cost == 8'd20 && !r_ill, "R8 cost", {24'd0, r_cost}, 32'd20);
    chk(n_rd - rd0 == 1, "R2 one read", n_rd - rd0, 32'd1);
    chk(last_sz == ((w == 8) ? 2'd0 : (w == 16) ? 2'd1 : 2'd2), "R2 size code",
        {30'd0, last_sz}, w);
    chk(ccr_o == {ccr_in[4], exp_nzvc(dcv, memv, w)}, "R4 flags",
        {27'd0, ccr_o}, {27'd0, ccr_in[4], exp_nzvc(dcv, memv, w)});
    getreg(dci, got);
    if (match) begin
      chk(n_wr - wr0 == 1, "R5 one write", n_wr - wr0, 32'd1);
      chk(mmem[adr] == ((memv & ~m) | (duv & m)), "R5 memory", mmem[adr], (memv & ~m) | (duv & m));
      chk(got == dcv, "R5 compare reg kept", got, dcv);
    end else begin
      chk(n_wr == wr0, "R6 no write", n_wr - wr0, 32'd0);
      chk(mmem[adr] == memv, "R6 memory kept", mmem[adr], memv);
      chk(got == ((dcv & ~m) | (memv & m)), "R6 merge", got, (dcv & ~m) | (memv & m));
    end
    getreg(dui, got);
    chk(got == duv, "R10 update reg untouched", got, duv);
  endtask

  initial begin
    logic [31:0] g, dcv, memv, duv, rd0, wr0, d0;
    bit legal;
    start_i = 0; opcode_i = 0; ext_i = 0; addr_i = 0; ccr_i = 0;
    reg_we_i = 0; reg_widx_i = 0; reg_wdata_i = 0; reg_ridx_i = 0;
    for (int i = 0; i < 16; i++) mmem[i] = 32'd0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !mem_req_o && !mem_lock_o, "R1 idle outputs",
        {28'd0, busy_o, done_o, mem_req_o, mem_lock_o}, 32'd0);
    chk(ccr_o == 5'd0, "R1 ccr", {27'd0, ccr_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      getreg(r[2:0], g);
      chk(g == 32'd0, "R1 register zero", g, 32'd0);
    end

    // main sweep: all size codes, matching and mismatching operands
    for (int sc = 0; sc < 8; sc++) begin
      for (int k = 0; k < 12; k++) begin
        for (int mt = 0; mt < 2; mt++) begin
          logic [31:0] m;
          int unsigned w;
          w   = (sc == 5) ? 8 : (sc == 6) ? 16 : 32;
          m   = msk_of(w);
          rng = next_rng(rng);
          dcv = edge_val(k) ^ (rng & 32'hFF00_0000 & {32{k[0]}});
          rng = next_rng(rng);
          duv = rng;
          rng = next_rng(rng);
          if (mt == 1) memv = (dcv & m) | (rng & ~m);
          else         memv = edge_val(k + 5 + sc);
          do_case(sc[2:0], 3'((k + sc) % 8), 3'((k + sc + 3) % 8), dcv, duv, memv,
                  3'(2 + (k % 5)), 4'((k + sc) % 16), {k[0], 4'(k + sc)});
        end
      end
    end

    // R3 addressing-mode sweep
    for (int md = 0; md < 8; md++) begin
      for (int rg = 0; rg < 8; rg++) begin
        legal = (md >= 2 && md <= 6) || (md == 7 && rg < 4);
        setreg(3'd2, 32'h0000_1111);
        setreg(3'd4, 32'hBEEF_0000);
        mmem[7] = 32'h0000_1111;
        rd0 = n_rd;
        wr0 = n_wr;
        run_op({4'b0000, 3'b111, 3'b011, 3'(md), 3'(rg)}, 16'h0102, 32'd7, 5'b10101);
        if (legal) begin
          chk(!r_ill && n_rd - rd0 == 1, "R3 legal mode accesses", n_rd - rd0, 32'd1);
        end else begin
          chk(r_ill && r_vec == 8'd4, "R3 illegal vector", {24'd0, r_vec}, 32'd4);
          chk(n_rd == rd0 && n_wr == wr0, "R3 no access", (n_rd - rd0) + (n_wr - wr0), 32'd0);
          chk(ccr_o == 5'b10101, "R3 flags kept", {27'd0, ccr_o}, 32'h15);
          getreg(3'd2, g);
          chk(g == 32'h0000_1111, "R3 register kept", g, 32'h0000_1111);
        end
      end
    end

    // R9 start while busy is ignored
    setreg(3'd1, 32'h0000_00AA);
    setreg(3'd3, 32'h0000_0055);
    setreg(3'd5, 32'h5555_5555);
    mmem[9] = 32'h0000_00AB;
    lat = 4;
    d0  = n_done;
    @(negedge clk);
    start_i = 1'b1; opcode_i = 16'h0ED1; ext_i = 16'h00C1; addr_i = 32'd9; ccr_i = 5'd0;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; opcode_i = 16'h0ED1; ext_i = 16'h0005; addr_i = 32'd9;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_done - d0 == 1, "R9 single completion", n_done - d0, 32'd1);
    getreg(3'd5, g);
    chk(g == 32'h5555_5555, "R9 second request ignored", g, 32'h5555_5555);
    getreg(3'd1, g);
    chk(g == 32'h0000_00AB, "R9 first request merged", g, 32'h0000_00AB);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule